// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the order in which column addresses are visited during one SDRAM burst. A mode write loads the burst length and the ordering type. These settings then stay in force until the next mode write, as a memory's mode register would hold them. A start pulse and a starting column then launch a burst. Every clock after that, the block presents one column address with a valid strobe until the burst runs out or a terminate input cuts it short.

A memory controller places the block beside its command logic. The controller issues the row and column commands and moves the data. The sequencer only says which column each data beat belongs to, and it raises a flag on the final beat of a fixed-length burst. Full-page bursts walk across the whole 256-column row and wrap from the top column to the bottom one. They run until terminated.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, colValid and lastBeat are low and the mode is burst length 1 with sequential ordering.
- R2: On a clock edge with modeWrite high, modeLen and modeIlv are captured. The modeLen codes are 0 for length 1, 1 for length 2, 2 for length 4, 3 for length 8 and 7 for full page, and codes 4 to 6 act as length 1. modeIlv set to 1 selects interleave. Changes on modeLen or modeIlv without modeWrite have no effect.
- R3: One cycle after a clock edge samples startPulse high, colValid is high and colAddr equals the sampled startCol. One beat follows per cycle after that.
- R4: In sequential mode with burst length BL, the low log2(BL) bits of colAddr count up from the start column's low bits and wrap inside the aligned block. The upper bits keep the start column's value.
- R5: In interleave mode with burst length BL, the low log2(BL) bits of beat n equal the start column's low bits XOR n. The upper bits keep the start column's value.
- R6: A full-page burst visits consecutive columns modulo 256, so column 255 is followed by column 0. It continues until terminated, and the interleave setting is ignored.
- R7: A fixed-length burst that is not interrupted produces exactly BL beats, and colValid is low in the cycle after the last one.
- R8: lastBeat is high exactly on the final beat of a fixed-length burst and never during a full-page burst.
- R9: When a clock edge samples terminate high during a burst, colValid is low in the cycle after that edge.
- R10: A startPulse during a burst restarts the sequence at the new startCol in the next cycle. It takes priority over terminate sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWrite | input | 1 | Captures modeLen and modeIlv |
| modeLen | input | 3 | Burst length code |
| modeIlv | input | 1 | 1 selects interleaved ordering |
| startPulse | input | 1 | Begins a burst |
| startCol | input | 8 | Starting column of the burst |
| terminate | input | 1 | Ends the current burst early |
| colValid | output | 1 | colAddr holds a beat of the burst |
| colAddr | output | 8 | Column address for the current beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench uses start columns that are not aligned to the burst block, in both ordering types. A design that carried the count into the upper bits, or that swapped XOR for addition, would then emit wrong columns partway through the burst. A full-page burst is started near column 255 and another is started with interleave selected. These catch a wrap that stalls or jumps, and an interleave setting wrongly applied to a whole page. Further runs cover a restart during a burst, start and terminate arriving at the same edge, a reserved length code, and mode pins changed without a write. A priority error, stale mode latching or a stray lastBeat would each show up as an unexpected or missing beat on the scoreboard.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic stop;
  } seqStrobe_t;

  localparam logic [2:0] LEN_ONE   = 3'd0;
  localparam logic [2:0] LEN_TWO   = 3'd1;
  localparam logic [2:0] LEN_FOUR  = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_PAGE  = 3'd7;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrite,
  input  logic [2:0]       modeLen,
  input  logic             modeIlv,
  input  logic             startPulse,
  input  logic             terminate,
  input  logic             beatFinal,
  output seqStrobe_t       strb,
  output logic [COL_W-1:0] lenMask,
  output logic             ilvOn,
  output logic             fullPage,
  output logic             colValid,
  output logic             lastBeat
);
  logic [2:0] lenCodeQ;
  logic       ilvQ;
  logic       activeQ;

  // Mode register: written only by modeWrite (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCodeQ <= LEN_ONE;
      ilvQ     <= 1'b0;
    end else if (modeWrite) begin
      lenCodeQ <= modeLen;
      ilvQ     <= modeIlv;
    end
  end

  always_comb begin
    case (lenCodeQ)
      LEN_TWO:   lenMask = COL_W'(1);
      LEN_FOUR:  lenMask = COL_W'(3);
      LEN_EIGHT: lenMask = COL_W'(7);
      LEN_PAGE:  lenMask = '1;
      default:   lenMask = '0;
    endcase
  end

  assign fullPage = (lenCodeQ == LEN_PAGE);
  assign ilvOn    = ilvQ && !fullPage;

  always_comb begin
    strb.load = startPulse;
    strb.stop = activeQ && !startPulse && (terminate || (beatFinal && !fullPage));
    strb.step = activeQ && !startPulse && !strb.stop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          activeQ <= 1'b0;
    else if (strb.load) activeQ <= 1'b1;
    else if (strb.stop) activeQ <= 1'b0;
  end

  assign colValid = activeQ;
  assign lastBeat = activeQ && !fullPage && beatFinal;

  p_start_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> colValid);

  p_term_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && terminate && !startPulse) |=> !colValid);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startPulse) |=> !colValid);
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [COL_W-1:0] startColIn,
  input  logic [COL_W-1:0] lenMask,
  input  logic             ilvOn,
  input  logic             fullPage,
  output logic             beatFinal,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] startColQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;
  logic [COL_W-1:0] pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startColQ <= '0;
      beatQ     <= '0;
    end else if (strb.load) begin
      startColQ <= startColIn;
      beatQ     <= '0;
    end else if (strb.step) begin
      beatQ     <= beatQ + 1'b1;
    end
  end

  assign seqLow    = startColQ + beatQ;
  assign ilvLow    = startColQ ^ beatQ;
  assign pick      = ilvOn ? ilvLow : seqLow;
  assign beatFinal = (beatQ == lenMask);

  // Bits inside the burst block take the ordered value, the rest hold the start column
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign colAddr[i] = lenMask[i] ? pick[i] : startColQ[i];
  end

  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (colAddr == $past(startColIn)));

  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && fullPage && (colAddr == '1)) |=> (colAddr == '0));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrite,
  input  logic [2:0]       modeLen,
  input  logic             modeIlv,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic             terminate,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);
  seqStrobe_t       strb;
  logic [COL_W-1:0] lenMask;
  logic             ilvOn;
  logic             fullPage;
  logic             beatFinal;

  bseq_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeWrite(modeWrite), .modeLen(modeLen),
    .modeIlv(modeIlv), .startPulse(startPulse), .terminate(terminate),
    .beatFinal(beatFinal), .strb(strb), .lenMask(lenMask), .ilvOn(ilvOn),
    .fullPage(fullPage), .colValid(colValid), .lastBeat(lastBeat)
  );

  bseq_datapath #(.COL_W(COL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startColIn(startCol),
    .lenMask(lenMask), .ilvOn(ilvOn), .fullPage(fullPage),
    .beatFinal(beatFinal), .colAddr(colAddr)
  );
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWrite = 1'b0;
  logic [2:0] modeLen = 3'd0;
  logic       modeIlv = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] startCol = 8'd0;
  logic       terminate = 1'b0;
  logic       colValid;
  logic [7:0] colAddr;
  logic       lastBeat;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    done = 1'b0;
  int    curLen = 0;
  bit    curIlv = 1'b0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rstN(rstN), .modeWrite(modeWrite), .modeLen(modeLen),
    .modeIlv(modeIlv), .startPulse(startPulse), .startCol(startCol),
    .terminate(terminate), .colValid(colValid), .colAddr(colAddr),
    .lastBeat(lastBeat)
  );

  function automatic int burstLen(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expAddr(logic [7:0] s, int beat);
    int bl = burstLen(curLen);
    int msk = bl - 1;
    int low;
    if (curLen == 7) return 8'((int'(s) + beat) % 256);
    low = curIlv ? ((int'(s) ^ beat) & msk) : ((int'(s) + beat) & msk);
    return 8'((int'(s) & ~msk) | low);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushBeats(logic [7:0] s, int n, string tag);
    int bl = burstLen(curLen);
    for (int b = 0; b < n; b++) begin
      expQ.push_back({(curLen != 7) && (b == bl - 1), expAddr(s, b)});
      tagQ.push_back(tag);
    end
  endtask

  task automatic setMode(int code, bit ilv);
    @(negedge clk);
    modeWrite = 1'b1; modeLen = 3'(code); modeIlv = ilv;
    @(negedge clk);
    modeWrite = 1'b0;
    curLen = code; curIlv = ilv;
  endtask

  task automatic endCheck(string tag);
    #1;
    check({tag, " queue drained"}, 32'(expQ.size()), 32'd0);
    check({tag, " valid low after burst"}, 32'(colValid), 32'd0);
  endtask

  // termAt < 0: run to natural end
  task automatic doBurst(logic [7:0] s, int termAt, string tag);
    int bl = burstLen(curLen);
    int n;
    if (termAt < 0) n = bl;
    else n = (curLen == 7 || termAt + 1 < bl) ? termAt + 1 : bl;
    pushBeats(s, n, tag);
    @(negedge clk);
    startPulse = 1'b1; startCol = s;
    @(negedge clk);
    startPulse = 1'b0;
    if (termAt >= 0) begin
      repeat (termAt) @(negedge clk);
      terminate = 1'b1;
      @(negedge clk);
      terminate = 1'b0;
    end else begin
      repeat (bl) @(negedge clk);
    end
    endCheck(tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && colValid) begin
      if (expQ.size() == 0) begin
        testsRun++; testsFailed++;
        $display("FAIL unexpected beat actual=%0h expected=none", colAddr);
      end else begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " beat"}, 32'({lastBeat, colAddr}), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(colValid), 32'd0);
    check("R1 reset last", 32'(lastBeat), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle valid", 32'(colValid), 32'd0);

    // R1 default mode: single beat, flagged last (R7, R8)
    doBurst(8'h37, -1, "R1 default length");

    // R4 sequential BL8 unaligned start, R7 count, R8 last
    setMode(3, 1'b0);
    doBurst(8'h2D, -1, "R4 seq bl8");
    setMode(1, 1'b0);
    doBurst(8'h0F, -1, "R4 seq bl2");

    // R5 interleave
    setMode(2, 1'b1);
    doBurst(8'h52, -1, "R5 ilv bl4");
    setMode(3, 1'b1);
    doBurst(8'hC5, -1, "R5 ilv bl8");

    // R2 pins changed without modeWrite: still BL8 interleave
    @(negedge clk);
    modeLen = 3'd1; modeIlv = 1'b0;
    doBurst(8'h63, -1, "R2 ignored pins");

    // R2 reserved code acts as length 1
    setMode(5, 1'b0);
    doBurst(8'h9A, -1, "R2 reserved code");

    // R6 full-page wrap, R9 terminate
    setMode(7, 1'b0);
    doBurst(8'd250, 9, "R6 page wrap");
    setMode(7, 1'b1);
    doBurst(8'h11, 5, "R6 page ignores ilv");
    doBurst(8'h03, 259, "R6 page long");

    // R9 early terminate of fixed burst (no last flag)
    setMode(3, 1'b0);
    doBurst(8'h44, 3, "R9 terminate bl8");

    // R10 restart during burst
    pushBeats(8'h03, 3, "R10 restart first");
    pushBeats(8'h40, 8, "R10 restart second");
    @(negedge clk); startPulse = 1'b1; startCol = 8'h03;
    @(negedge clk); startPulse = 1'b0;
    @(negedge clk);
    @(negedge clk); startPulse = 1'b1; startCol = 8'h40;
    @(negedge clk); startPulse = 1'b0;
    repeat (8) @(negedge clk);
    endCheck("R10 restart");

    // R10 start wins over terminate at the same edge
    pushBeats(8'h10, 2, "R10 priority first");
    pushBeats(8'h21, 8, "R10 priority second");
    @(negedge clk); startPulse = 1'b1; startCol = 8'h10;
    @(negedge clk); startPulse = 1'b0;
    @(negedge clk); startPulse = 1'b1; terminate = 1'b1; startCol = 8'h21;
    @(negedge clk); startPulse = 1'b0; terminate = 1'b0;
    repeat (8) @(negedge clk);
    endCheck("R10 priority");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule